// File: doc/BRIEF.md
# Partitioned Lane Shifter with Bit Stream Packer

This block is a 64-bit fixed-point shift unit for a signal-processing datapath. Each operation takes a 64-bit operand and treats it as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane is shifted or rotated on its own, and no bit moves from one lane into another. A signed amount chooses the direction. A separate mode bit chooses between a logical and an arithmetic right shift.

The same unit also sets, clears, toggles or tests one chosen bit of the operand. It holds a 64-bit bit-stream buffer that packs fields of 1 to 32 bits one after another, starting at the most significant end, and hands them back in the same order. Software uses the buffer to build a variable-length bitstream or to parse one. Each accepted operation returns its outputs from a register one clock later.

Top module: `lane_shift_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge. Reset clears `out_valid`, `result`, `zero_flag`, `fifo_fill` and `fifo_err` to zero.
- R2: `lane_mode` selects the lane width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. A shift or rotate never moves a bit across a lane boundary.
- R3: Op 0 (shift) shifts every lane left by `shamt` when `shamt` (two's complement) is positive or zero. When it is negative, every lane shifts right by its magnitude. A right shift fills with the lane's sign bit when `arith` is 1 and with zeros when `arith` is 0.
- R4: A shift whose magnitude is equal to or greater than the lane width gives all zeros. The one exception is an arithmetic right shift, which gives copies of the lane's sign bit.
- R5: Op 1 (rotate) rotates every lane left for a positive or zero `shamt` and right for a negative one, by the magnitude modulo the lane width. `arith` is ignored.
- R6: Ops 2, 3 and 4 set, clear and toggle bit `bit_sel` of the full 64-bit operand. For shift, rotate and these three ops, `zero_flag` is 1 when the new `result` is zero.
- R7: Op 5 (test) leaves `result` unchanged. It sets `zero_flag` to 1 when operand bit `bit_sel` is 0 and to 0 otherwise.
- R8: Op 6 (append) takes the length L = `field_len`+1 (1..32). It places the low L bits of `field_data`, most significant first, right after the bits already held at the MSB end of the buffer, then raises `fifo_fill` by L and leaves `result` unchanged.
- R9: Op 7 (extract) puts the oldest L buffered bits into `result`, right-aligned and zero-extended. The first bit out becomes the most significant of the L bits. `fifo_fill` drops by L.
- R10: An append that would take the fill above 64, or an extract of more bits than are held, sets `fifo_err`. The buffer and fill stay unchanged. `fifo_err` shows only the most recent op, so any other op clears it. Ops 6 and 7 never change `zero_flag`.
- R11: A cycle without `in_valid` changes no output and leaves `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| op | input | 3 | Operation code (R3 to R10) |
| lane_mode | input | 2 | Lane width select |
| shamt | input | 8 | Signed shift or rotate amount |
| arith | input | 1 | Arithmetic right shift select |
| operand | input | 64 | Data operand |
| bit_sel | input | 6 | Bit index for bit operations |
| field_len | input | 5 | Field length minus one for the buffer |
| field_data | input | 32 | Field to append (low bits used) |
| out_valid | output | 1 | Result of an accepted op |
| result | output | 64 | Data result |
| zero_flag | output | 1 | Zero indication |
| fifo_fill | output | 7 | Bits held in the buffer |
| fifo_err | output | 1 | Overflow or underflow on the last op |

## Verification
Every result, flag and the fill count arrive one clock after the edge that accepts the request, so each one is due in the cycle that follows. The driver applies a request on the falling edge and pushes its expected item. The monitor pops that item one nanosecond after the next rising edge, only when `out_valid` is high, and flags any output that appears with nothing expected. The buffer model is a queue of bits that the bench keeps on its own, so the fill and the error outcome are known before the design answers. Idle cycles are checked at the same sampling point to confirm that nothing moves.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    OP_SHIFT  = 3'd0,
    OP_ROTATE = 3'd1,
    OP_BSET   = 3'd2,
    OP_BCLR   = 3'd3,
    OP_BTGL   = 3'd4,
    OP_BTEST  = 3'd5,
    OP_FPUSH  = 3'd6,
    OP_FPULL  = 3'd7
  } lsu_op_e;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lsu_lane_e;
endpackage

// File: rtl/lsu_lane_shift.sv
module lsu_lane_shift #(
  parameter int W       = 8,
  parameter int SHAMT_W = 8
) (
  input  logic [W-1:0]       din,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               arith,
  input  logic               rotate,
  output logic [W-1:0]       dout
);
  localparam int RW = $clog2(W);

  logic [SHAMT_W:0] amt_ext;
  logic [SHAMT_W:0] mag;
  logic             go_right;
  logic             too_far;
  logic [RW-1:0]    sh;
  logic [2*W-1:0]   dbl_l;
  logic [2*W-1:0]   dbl_r;
  logic [W-1:0]     fill_v;

  always_comb begin
    amt_ext  = {amt[SHAMT_W-1], amt};
    go_right = amt[SHAMT_W-1];
    mag      = go_right ? (~amt_ext + 1'b1) : amt_ext;
    too_far  = (mag >= (SHAMT_W+1)'(W));
    sh       = mag[RW-1:0];
    dbl_l    = {din, din} << sh;
    dbl_r    = {din, din} >> sh;
    fill_v   = (arith && din[W-1]) ? {W{1'b1}} : {W{1'b0}};
    if (rotate) begin
      dout = go_right ? dbl_r[W-1:0] : dbl_l[2*W-1:W];
    end else if (!go_right) begin
      dout = too_far ? {W{1'b0}} : (din << sh);
    end else if (too_far) begin
      dout = fill_v;
    end else if (arith) begin
      dout = W'($signed(din) >>> sh);
    end else begin
      dout = din >> sh;
    end
  end
endmodule

// File: rtl/lsu_bit_manip.sv
module lsu_bit_manip
  import lsu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  lsu_op_e           op,
  input  logic [DATA_W-1:0] operand,
  input  logic [SEL_W-1:0]  bit_sel,
  output logic [DATA_W-1:0] data_out,
  output logic              sel_bit
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask    = {{(DATA_W-1){1'b0}}, 1'b1} << bit_sel;
    sel_bit = operand[bit_sel];
    unique case (op)
      OP_BSET: data_out = operand | mask;
      OP_BCLR: data_out = operand & ~mask;
      OP_BTGL: data_out = operand ^ mask;
      default: data_out = operand;
    endcase
  end
endmodule

// File: rtl/lsu_bit_fifo.sv
module lsu_bit_fifo #(
  parameter int BUF_W   = 64,
  parameter int FIELD_W = 32,
  localparam int LEN_W  = $clog2(FIELD_W),
  localparam int FILL_W = $clog2(BUF_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pull,
  input  logic [LEN_W-1:0]   len_m1,
  input  logic [FIELD_W-1:0] field_in,
  output logic [FIELD_W-1:0] field_out,
  output logic [FILL_W-1:0]  fill,
  output logic               op_err
);
  logic [BUF_W-1:0]   buf_q, buf_d;
  logic [FILL_W-1:0]  fill_q, fill_d;
  logic [FILL_W-1:0]  len;
  logic [FIELD_W-1:0] keep_mask;
  logic [BUF_W-1:0]   aligned;
  logic [BUF_W-1:0]   pulled;
  logic               ovf, udf;

  always_comb begin
    len       = FILL_W'(len_m1) + 1'b1;
    ovf       = (fill_q + len) > FILL_W'(BUF_W);
    udf       = len > fill_q;
    keep_mask = {FIELD_W{1'b1}} >> (FILL_W'(FIELD_W) - len);
    aligned   = ({field_in & keep_mask, {(BUF_W-FIELD_W){1'b0}}}
                 << (FILL_W'(FIELD_W) - len)) >> fill_q;
    pulled    = buf_q >> (FILL_W'(BUF_W) - len);
    field_out = pulled[FIELD_W-1:0];
    op_err    = (push && ovf) || (pull && udf);
    buf_d     = buf_q;
    fill_d    = fill_q;
    if (push && !ovf) begin
      buf_d  = buf_q | aligned;
      fill_d = fill_q + len;
    end else if (pull && !udf) begin
      buf_d  = buf_q << len;
      fill_d = fill_q - len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      fill_q <= '0;
    end else if (push || pull) begin
      buf_q  <= buf_d;
      fill_q <= fill_d;
    end
  end

  assign fill = fill_q;
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 8,
  parameter int FIELD_W = 32,
  localparam int SEL_W  = $clog2(DATA_W),
  localparam int LEN_W  = $clog2(FIELD_W),
  localparam int FILL_W = $clog2(DATA_W) + 1,
  localparam int NMODE  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         op,
  input  logic [1:0]         lane_mode,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               arith,
  input  logic [DATA_W-1:0]  operand,
  input  logic [SEL_W-1:0]   bit_sel,
  input  logic [LEN_W-1:0]   field_len,
  input  logic [FIELD_W-1:0] field_data,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               zero_flag,
  output logic [FILL_W-1:0]  fifo_fill,
  output logic               fifo_err
);
  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  lsu_op_e   op_e;
  lsu_lane_e mode_e;
  logic      is_rot;
  assign op_e   = lsu_op_e'(op);
  assign mode_e = lsu_lane_e'(lane_mode);
  assign is_rot = (op_e == OP_ROTATE);

  logic [DATA_W-1:0] by_mode [NMODE];

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    localparam int LW = 8 << m;
    for (genvar l = 0; l < DATA_W / LW; l++) begin : g_lane
      lsu_lane_shift #(.W(LW), .SHAMT_W(SHAMT_W)) i_lane (
        .din    (operand[l*LW +: LW]),
        .amt    (shamt),
        .arith  (arith),
        .rotate (is_rot),
        .dout   (by_mode[m][l*LW +: LW])
      );
    end
  end

  logic [DATA_W-1:0] shift_res;
  assign shift_res = by_mode[mode_e];

  logic [DATA_W-1:0] bm_res;
  logic              bm_bit;

  lsu_bit_manip #(.DATA_W(DATA_W)) i_bits (
    .op       (op_e),
    .operand  (operand),
    .bit_sel  (bit_sel),
    .data_out (bm_res),
    .sel_bit  (bm_bit)
  );

  logic               f_push, f_pull, f_err;
  logic [FIELD_W-1:0] f_out;

  assign f_push = in_valid && (op_e == OP_FPUSH);
  assign f_pull = in_valid && (op_e == OP_FPULL);

  lsu_bit_fifo #(.BUF_W(DATA_W), .FIELD_W(FIELD_W)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .push      (f_push),
    .pull      (f_pull),
    .len_m1    (field_len),
    .field_in  (field_data),
    .field_out (f_out),
    .fill      (fifo_fill),
    .op_err    (f_err)
  );

  logic [DATA_W-1:0] result_d;
  logic              zero_d, err_d;

  always_comb begin
    result_d = result;
    zero_d   = zero_flag;
    err_d    = 1'b0;
    unique case (op_e)
      OP_SHIFT, OP_ROTATE: begin
        result_d = shift_res;
        zero_d   = (shift_res == '0);
      end
      OP_BSET, OP_BCLR, OP_BTGL: begin
        result_d = bm_res;
        zero_d   = (bm_res == '0);
      end
      OP_BTEST: zero_d = ~bm_bit;
      OP_FPUSH: err_d = f_err;
      OP_FPULL: begin
        err_d = f_err;
        if (!f_err) result_d = DATA_W'(f_out);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) out_valid <= 1'b0;
    else             out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      result    <= '0;
      zero_flag <= 1'b0;
      fifo_err  <= 1'b0;
    end else if (in_valid) begin
      result    <= result_d;
      zero_flag <= zero_d;
      fifo_err  <= err_d;
    end
  end
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker
  import lsu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [4:0]  field_len,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        zero_flag,
  input logic [6:0]  fifo_fill,
  input logic        fifo_err
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(fifo_fill) && $stable(zero_flag)); // R11

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BTEST) |=> $stable(result)); // R7

  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= 7'd64); // R8

  AST_APPEND_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_FPUSH && (8'(fifo_fill) + 8'(field_len) + 8'd1 <= 8'd64))
    |=> (8'(fifo_fill) == 8'($past(fifo_fill)) + 8'($past(field_len)) + 8'd1) && !fifo_err); // R8

  AST_ERR_FREEZES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fifo_err) |-> $stable(fifo_fill)); // R10

  AST_FIFO_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_FPUSH || op == OP_FPULL)) |=> $stable(zero_flag)); // R10
endmodule

bind lane_shift_unit lsu_checker i_lsu_checker (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .in_valid  (in_valid),
  .op        (op),
  .field_len (field_len),
  .out_valid (out_valid),
  .result    (result),
  .zero_flag (zero_flag),
  .fifo_fill (fifo_fill),
  .fifo_err  (fifo_err)
);

// File: tb/test_lane_shift_unit.sv
module test_lane_shift_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  lane_mode;
  logic [7:0]  shamt;
  logic        arith;
  logic [63:0] operand;
  logic [5:0]  bit_sel;
  logic [4:0]  field_len;
  logic [31:0] field_data;
  logic        out_valid;
  logic [63:0] result;
  logic        zero_flag;
  logic [6:0]  fifo_fill;
  logic        fifo_err;

  lane_shift_unit i_lane_shift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .lane_mode(lane_mode), .shamt(shamt), .arith(arith), .operand(operand),
    .bit_sel(bit_sel), .field_len(field_len), .field_data(field_data),
    .out_valid(out_valid), .result(result), .zero_flag(zero_flag),
    .fifo_fill(fifo_fill), .fifo_err(fifo_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    string       req;
    logic [63:0] res;
    logic        zf;
    logic [6:0]  fill;
    logic        err;
  } exp_t;

  exp_t        sb[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;
  bit          fq[$];
  logic [63:0] m_res   = '0;
  logic        m_zf    = 1'b0;

  function automatic logic [63:0] lane_model(int opc, int mode, int s, bit ar,
                                             logic [63:0] x);
    logic [63:0] y;
    int w, m, src;
    bit right;
    w = 8 << mode;
    right = (s < 0);
    m = right ? -s : s;
    y = '0;
    for (int base = 0; base < 64; base += w) begin
      for (int i = 0; i < w; i++) begin
        if (opc == 1) begin
          src = right ? (i + m) % w : ((i - (m % w)) + w) % w;
          y[base+i] = x[base+src];
        end else if (!right) begin
          src = i - m;
          y[base+i] = (src >= 0) ? x[base+src] : 1'b0;
        end else begin
          src = i + m;
          y[base+i] = (src < w) ? x[base+src] : (ar & x[base+w-1]);
        end
      end
    end
    return y;
  endfunction

  task automatic issue(string req, int opc, int mode, int s, bit ar,
                       logic [63:0] x, int sel, int len, logic [31:0] fd);
    exp_t e;
    logic [63:0] v;
    bit err;
    err = 1'b0;
    in_valid = 1'b1; op = 3'(opc); lane_mode = 2'(mode); shamt = 8'(s);
    arith = ar; operand = x; bit_sel = 6'(sel); field_len = 5'(len - 1);
    field_data = fd;
    case (opc)
      0, 1: begin m_res = lane_model(opc, mode, s, ar, x); m_zf = (m_res == 0); end
      2: begin m_res = x; m_res[sel] = 1'b1; m_zf = (m_res == 0); end
      3: begin m_res = x; m_res[sel] = 1'b0; m_zf = (m_res == 0); end
      4: begin m_res = x; m_res[sel] = ~x[sel]; m_zf = (m_res == 0); end
      5: m_zf = ~x[sel];
      6: begin
        if (fq.size() + len > 64) err = 1'b1;
        else for (int i = len - 1; i >= 0; i--) fq.push_back(fd[i]);
      end
      default: begin
        if (len > fq.size()) err = 1'b1;
        else begin
          v = '0;
          for (int i = 0; i < len; i++) v = {v[62:0], fq.pop_front()};
          m_res = v;
        end
      end
    endcase
    e.req = req; e.res = m_res; e.zf = m_zf; e.fill = 7'(fq.size()); e.err = err;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: outputs are due one cycle after the accepting edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (out_valid) begin
        n_tests++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R1: out_valid got 1 exp 0 (nothing pending)");
        end else begin
          e = sb.pop_front();
          if (result !== e.res || zero_flag !== e.zf || fifo_fill !== e.fill ||
              fifo_err !== e.err) begin
            n_fail++;
            $display("FAIL %s: res/zf/fill/err got %h/%b/%0d/%b exp %h/%b/%0d/%b",
                     e.req, result, zero_flag, fifo_fill, fifo_err,
                     e.res, e.zf, e.fill, e.err);
          end
        end
      end
    end
  end

  task automatic direct(string req, bit ok, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    in_valid = 0; op = 0; lane_mode = 0; shamt = 0; arith = 0; operand = 0;
    bit_sel = 0; field_len = 0; field_data = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    direct("R1", {out_valid, result, zero_flag, fifo_fill, fifo_err} == '0,
           {out_valid, zero_flag, fifo_err, fifo_fill}, 64'h0);

    // R2 R3 shifts within lanes
    issue("R2", 0, 0, 3, 0, 64'h8181_8181_F00F_0102, 0, 1, 0);
    issue("R3", 0, 0, -2, 1, 64'h80FF_7F01_8040_2010, 0, 1, 0);
    issue("R3", 0, 0, -2, 0, 64'h80FF_7F01_8040_2010, 0, 1, 0);
    issue("R2", 0, 1, 4, 0, 64'hF123_4567_89AB_CDEF, 0, 1, 0);
    issue("R3", 0, 2, -31, 1, 64'h8000_0000_7FFF_FFFF, 0, 1, 0);
    issue("R3", 0, 3, 4, 0, 64'h0123_4567_89AB_CDEF, 0, 1, 0);
    // R4 over-range amounts
    issue("R4", 0, 0, 8, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0);
    issue("R4", 0, 0, -9, 1, 64'h8000_8000_7F00_FF01, 0, 1, 0);
    issue("R4", 0, 1, -20, 0, 64'h8000_8000_8000_8000, 0, 1, 0);
    issue("R4", 0, 3, -128, 1, 64'h8000_0000_0000_0001, 0, 1, 0);
    // R5 rotates
    issue("R5", 1, 0, 3, 1, 64'h8101_F00F_0102_0304, 0, 1, 0);
    issue("R5", 1, 0, -3, 0, 64'h8101_F00F_0102_0304, 0, 1, 0);
    issue("R5", 1, 0, 11, 0, 64'h8101_F00F_0102_0304, 0, 1, 0);
    issue("R5", 1, 3, -1, 0, 64'h0000_0000_0000_0001, 0, 1, 0);
    // R6 bit set/clear/toggle
    issue("R6", 2, 0, 0, 0, 64'h0, 63, 1, 0);
    issue("R6", 3, 0, 0, 0, 64'h0000_0000_0000_0001, 0, 1, 0);
    issue("R6", 4, 0, 0, 0, 64'h0000_0000_0000_00F0, 5, 1, 0);
    // R7 test: result held
    issue("R7", 5, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFD, 1, 1, 0);
    issue("R7", 5, 0, 0, 0, 64'h1, 0, 1, 0);
    // R8 R9 R10 bit stream
    issue("R8", 6, 0, 0, 0, 0, 0, 5, 32'hFFFF_FFF5);
    issue("R8", 6, 0, 0, 0, 0, 0, 32, 32'hDEAD_BEEF);
    issue("R8", 6, 0, 0, 0, 0, 0, 27, 32'h0555_AAAA);
    issue("R10", 6, 0, 0, 0, 0, 0, 1, 32'h1);
    issue("R9", 7, 0, 0, 0, 0, 0, 3, 0);
    issue("R9", 7, 0, 0, 0, 0, 0, 32, 0);
    issue("R9", 7, 0, 0, 0, 0, 0, 29, 0);
    issue("R10", 7, 0, 0, 0, 0, 0, 1, 0);
    issue("R10", 0, 3, 0, 0, 64'h5, 0, 1, 0);
    // R11 idle cycles
    repeat (2) @(negedge clk);
    direct("R11", !out_valid && fifo_fill == 7'(fq.size()) && result == m_res,
           result, m_res);
    // mixed stream
    for (int k = 0; k < 60; k++) begin
      issue("R2", int'($urandom % 8), int'($urandom % 4), int'($urandom % 256) - 128,
            1'($urandom), {$urandom, $urandom}, int'($urandom % 64),
            int'($urandom % 32) + 1, $urandom);
    end
    repeat (3) @(negedge clk);
    direct("R11", !out_valid && sb.size() == 0, 64'(sb.size()), 64'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule